// File: doc/BRIEF.md
# Dual-Output Interrupt Router with Idle Wake

This block collects a vector of level-sensitive interrupt source lines and turns them into two processor request lines: a normal request and a fast request. Sources 0 to 10 are intended for single GPIO pins, source 11 for the combined request of GPIO pins 11 to 27, and sources 12 and above for on-chip peripherals. The block needs no acknowledge. A source stays pending for as long as its line is high.

Software owns three writable registers behind a small register bus. The enable register gates each source. The route register sends each enabled source to the normal or the fast output. Bit 0 of the control register selects which sources may end a wait-for-interrupt idle. Three read-only views show the raw lines, the normal-pending vector and the fast-pending vector. The writable registers read back as written, so their contents can be saved before sleep and restored afterwards.

A small idle state machine has three states. `ST_RUN` is normal execution. `ST_IDLE` is a wait-for-interrupt idle. `ST_WAKE` is a one-cycle wake announcement. The transitions are:
- enter-idle: `ST_RUN` to `ST_IDLE` when the idle request is high.
- wake-hit: `ST_IDLE` to `ST_WAKE` when a qualifying source is active.
- resume: `ST_WAKE` to `ST_RUN`, always.
- stay: every other case leaves the state unchanged.

Top module: `irq_fiq_router`

## Requirements
- R1: After reset, the enable, route and control registers read 0, both request outputs are low, the block is in `ST_RUN` (idle output low), and the wake output is low.
- R2: A read at address 0 returns the source lines before masking.
- R3: A read at address 1 returns source AND enable AND NOT route (the normal-pending vector).
- R4: A read at address 2 returns source AND enable AND route (the fast-pending vector). A route bit of 1 selects the fast output and 0 selects the normal output.
- R5: `irq_o` is the OR of the normal-pending vector and `fiq_o` is the OR of the fast-pending vector, each registered once. A change of a source line shows on the outputs after one clock edge. A change of an enable or route bit shows on the outputs one cycle after the write takes effect.
- R6: Sources are level-sensitive and need no acknowledge. Pending follows the line: it stays set while the line is high and clears when the line falls.
- R7: The enable (address 3) and route (address 4) registers read back the value written. The control register (address 5) stores only bit 0, and its other bits read 0. Addresses 6 and 7 read 0.
- R8: In `ST_RUN`, a high `wfi_req_i` moves the block to `ST_IDLE` at the next edge, and `core_idle_o` is then high.
- R9: With control bit 0 set, only a source that is both active and enabled ends idle. An active but disabled source leaves the block in `ST_IDLE`.
- R10: With control bit 0 clear, any active source ends idle, whatever its enable bit.
- R11: Leaving idle passes through `ST_WAKE` for exactly one cycle. In that cycle `wake_o` is high and `core_idle_o` is low. The block then returns to `ST_RUN`.
- R12: Writes to the read-only addresses 0, 1 and 2 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt source lines |
| wfi_req_i | input | 1 | Request to enter wait-for-interrupt idle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | NSRC | Write data |
| bus_rdata_o | output | NSRC | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Normal interrupt request (registered) |
| fiq_o | output | 1 | Fast interrupt request (registered) |
| core_idle_o | output | 1 | High while in `ST_IDLE` |
| wake_o | output | 1 | One-cycle pulse in `ST_WAKE` |

## Verification
A walking-one source is swept over every source position under two enable/route configurations. This separates masking from routing per bit, and each bit's result is checked on the raw, normal and fast views and on both outputs. A held-then-dropped source shows level behaviour without acknowledge, and a single-edge sample pins the output latency. Idle tests use an active but disabled source under each setting of the control bit, which tells the two wake policies apart. A later enable write then shows the one-cycle wake state.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RAW   = 3'd0;
    localparam logic [ADDR_W-1:0] A_NPEND = 3'd1;
    localparam logic [ADDR_W-1:0] A_FPEND = 3'd2;
    localparam logic [ADDR_W-1:0] A_EN    = 3'd3;
    localparam logic [ADDR_W-1:0] A_ROUTE = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAKE = 2'd2
    } idle_state_t;
endpackage

// File: rtl/irq_fiq_regs.sv
module irq_fiq_regs
    import irq_fiq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NSRC-1:0]   bus_wdata_i,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [NSRC-1:0]   npend_i,
    input  logic [NSRC-1:0]   fpend_i,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   route_q,
    output logic              wake_sel_q,
    output logic [NSRC-1:0]   rdata_o
);
    // Only bit 0 of the control write data is stored.
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata_i[NSRC-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            route_q    <= '0;
            wake_sel_q <= 1'b0;
        end else if (bus_wr_i) begin
            unique case (bus_addr_i)
                A_EN:    en_q       <= bus_wdata_i;
                A_ROUTE: route_q    <= bus_wdata_i;
                A_CTRL:  wake_sel_q <= bus_wdata_i[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr_i)
            A_RAW:   rdata_o = raw_i;
            A_NPEND: rdata_o = npend_i;
            A_FPEND: rdata_o = fpend_i;
            A_EN:    rdata_o = en_q;
            A_ROUTE: rdata_o = route_q;
            A_CTRL:  rdata_o = {{(NSRC-1){1'b0}}, wake_sel_q};
            default: rdata_o = '0;
        endcase
    end

    p_en_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_EN) |=> (en_q == $past(bus_wdata_i)));

    p_ro_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i <= A_FPEND) |=>
            ($stable(en_q) && $stable(route_q) && $stable(wake_sel_q)));
endmodule

// File: rtl/irq_fiq_route.sv
module irq_fiq_route #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] route_i,
    output logic [NSRC-1:0] npend_o,
    output logic [NSRC-1:0] fpend_o,
    output logic            irq_o,
    output logic            fiq_o
);
    logic [NSRC-1:0] live;

    assign live    = src_i & en_i;
    assign npend_o = live & ~route_i;
    assign fpend_o = live & route_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |npend_o;
            fiq_o <= |fpend_o;
        end
    end

    p_npend_needs_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (npend_o & ~src_i) == '0);

    p_irq_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|$past(npend_o)));

    p_fiq_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (|$past(fpend_o)));
endmodule

// File: rtl/irq_fiq_idle.sv
module irq_fiq_idle
    import irq_fiq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            wake_sel_i,
    input  logic            wfi_req_i,
    output logic            core_idle_o,
    output logic            wake_o
);
    idle_state_t state_q, state_d;
    logic        wake_hit;

    assign wake_hit = wake_sel_i ? (|(src_i & en_i)) : (|src_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (wfi_req_i) state_d = ST_IDLE;
            ST_IDLE: if (wake_hit)  state_d = ST_WAKE;
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        core_idle_o = 1'b0;
        wake_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: core_idle_o = 1'b1;
            ST_WAKE: wake_o      = 1'b1;
            default: ;
        endcase
    end

    p_enter_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wfi_req_i) |=> (state_q == ST_IDLE));

    p_masked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wake_sel_i && (src_i & en_i) == '0) |=> (state_q == ST_IDLE));

    p_any_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wake_sel_i && src_i != '0) |=> (state_q == ST_WAKE));

    p_wake_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> (state_q == ST_RUN));

    p_out_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_idle_o, wake_o}));
endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
    import irq_fiq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wfi_req_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NSRC-1:0]   bus_wdata_i,
    output logic [NSRC-1:0]   bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              core_idle_o,
    output logic              wake_o
);
    logic [NSRC-1:0] en_q, route_q, npend, fpend;
    logic            wake_sel_q;

    irq_fiq_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .raw_i(src_i), .npend_i(npend), .fpend_i(fpend),
        .en_q(en_q), .route_q(route_q), .wake_sel_q(wake_sel_q),
        .rdata_o(bus_rdata_o)
    );

    irq_fiq_route #(.NSRC(NSRC)) u_route (
        .clk(clk), .rst_n(rst_n),
        .src_i(src_i), .en_i(en_q), .route_i(route_q),
        .npend_o(npend), .fpend_o(fpend),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    irq_fiq_idle #(.NSRC(NSRC)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .src_i(src_i), .en_i(en_q), .wake_sel_i(wake_sel_q),
        .wfi_req_i(wfi_req_i),
        .core_idle_o(core_idle_o), .wake_o(wake_o)
    );
endmodule

// File: tb/sim_irq_fiq_router.sv
module sim_irq_fiq_router;
    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            wfi = 1'b0;
    logic            wr = 1'b0;
    logic [2:0]      addr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [NSRC-1:0] rdata;
    logic            irq, fiq, idle, wake;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_fiq_router #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wfi_req_i(wfi),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
        .core_idle_o(idle), .wake_o(wake)
    );

    task automatic check(input bit ok, input string req, input logic [NSRC-1:0] act,
                         input logic [NSRC-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [NSRC-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [NSRC-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(input logic [NSRC-1:0] m, input logic [NSRC-1:0] l);
        logic [NSRC-1:0] v, en_x, ex_n, ex_f;
        bus_write(3'd3, m);
        bus_write(3'd4, l);
        for (int i = 0; i < NSRC; i++) begin
            @(negedge clk);
            src = NSRC'(1) << i;
            settle();
            ex_n = src & m & ~l;
            ex_f = src & m & l;
            bus_read(3'd0, v); check(v == src, "R2 raw view", v, src);
            bus_read(3'd1, v); check(v == ex_n, "R3 normal pending", v, ex_n);
            bus_read(3'd2, v); check(v == ex_f, "R4 fast pending", v, ex_f);
            en_x = {31'b0, |ex_n};
            check(irq == |ex_n, "R5 irq_o", {31'b0, irq}, en_x);
            en_x = {31'b0, |ex_f};
            check(fiq == |ex_f, "R5 fiq_o", {31'b0, fiq}, en_x);
        end
        @(negedge clk);
        src = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held
        bus_read(3'd3, v); check(v == '0, "R1 enable reset", v, '0);
        bus_read(3'd4, v); check(v == '0, "R1 route reset", v, '0);
        bus_read(3'd5, v); check(v == '0, "R1 control reset", v, '0);
        check({irq, fiq, idle, wake} == 4'b0, "R1 outputs reset",
              {28'b0, irq, fiq, idle, wake}, '0);
        rst_n = 1'b1;

        // R7 readback
        bus_write(3'd3, 32'hDEAD_BEEF);
        bus_read(3'd3, v); check(v == 32'hDEAD_BEEF, "R7 enable readback", v, 32'hDEAD_BEEF);
        bus_write(3'd4, 32'h1234_5678);
        bus_read(3'd4, v); check(v == 32'h1234_5678, "R7 route readback", v, 32'h1234_5678);
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_read(3'd5, v); check(v == 32'h1, "R7 control bit0 only", v, 32'h1);
        bus_read(3'd6, v); check(v == '0, "R7 spare address", v, '0);

        // R12 read-only writes ignored
        for (int a = 0; a < 3; a++) bus_write(3'(a), 32'h0F0F_0F0F);
        bus_read(3'd3, v); check(v == 32'hDEAD_BEEF, "R12 enable kept", v, 32'hDEAD_BEEF);
        bus_read(3'd4, v); check(v == 32'h1234_5678, "R12 route kept", v, 32'h1234_5678);
        bus_read(3'd5, v); check(v == 32'h1, "R12 control kept", v, 32'h1);

        // R2..R5 sweeps
        sweep(32'hA5A5_5A5A, 32'h0F0F_F0F0);
        sweep(32'hFFFF_FFFF, 32'h3333_CCCC);

        // R5 latency: one edge from source change to output
        bus_write(3'd3, 32'h0000_0800);
        bus_write(3'd4, 32'h0);
        @(negedge clk);
        src = 32'h0000_0800;
        #0.5;
        check(irq == 1'b0, "R5 irq before edge", {31'b0, irq}, '0);
        @(negedge clk);
        check(irq == 1'b1, "R5 irq after one edge", {31'b0, irq}, 32'h1);

        // R6 level, no acknowledge
        repeat (5) @(negedge clk);
        bus_read(3'd1, v); check(v == 32'h0000_0800, "R6 held pending", v, 32'h0000_0800);
        check(irq == 1'b1, "R6 irq held", {31'b0, irq}, 32'h1);
        src = '0;
        @(negedge clk);
        bus_read(3'd1, v); check(v == '0, "R6 pending cleared", v, '0);
        check(irq == 1'b0, "R6 irq dropped", {31'b0, irq}, '0);

        // R8, R9, R11: control bit set, disabled source must not wake
        bus_write(3'd5, 32'h1);
        bus_write(3'd3, 32'h0);
        @(negedge clk);
        src = 32'h0000_0020;
        wfi = 1'b1;
        @(negedge clk);
        wfi = 1'b0;
        check(idle == 1'b1, "R8 entered idle", {31'b0, idle}, 32'h1);
        repeat (4) @(negedge clk);
        check(idle == 1'b1, "R9 disabled source keeps idle", {31'b0, idle}, 32'h1);
        bus_write(3'd3, 32'h0000_0020);
        check(idle == 1'b1 && wake == 1'b0, "R9 idle until enable seen",
              {30'b0, idle, wake}, 32'h2);
        @(negedge clk);
        check(wake == 1'b1 && idle == 1'b0, "R11 wake state", {30'b0, idle, wake}, 32'h1);
        @(negedge clk);
        check(wake == 1'b0 && idle == 1'b0, "R11 back to run", {30'b0, idle, wake}, '0);
        src = '0;

        // R10: control bit clear, disabled source wakes
        bus_write(3'd5, 32'h0);
        bus_write(3'd3, 32'h0);
        @(negedge clk);
        wfi = 1'b1;
        @(negedge clk);
        wfi = 1'b0;
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R10 idle with no source", {31'b0, idle}, 32'h1);
        src = 32'h0010_0000;
        @(negedge clk);
        check(wake == 1'b1, "R10 disabled source wakes", {31'b0, wake}, 32'h1);
        @(negedge clk);
        check(wake == 1'b0 && idle == 1'b0, "R10 resumed run", {30'b0, idle, wake}, '0);
        src = '0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule